// File: doc/BRIEF.md
# Dual-Syllable Instruction Fetcher

This block feeds an instruction decoder from a word-wide program memory in which every 28-bit word carries two 13-bit instructions, called syllables here, each followed by its own parity bit. The fetcher holds one fetched word, hands its syllables to the decoder one at a time, and reads the next word only once both syllables have been used. Memory traffic is therefore one read for every two instructions.

Each syllable is checked for odd parity before the decoder sees it. A syllable that fails the check is never offered as valid. It is dropped with a one-cycle failure pulse, and a sticky error flag is set that stays set until reset. A redirect input, driven when the program branches, loads a new 15-bit word address and a starting syllable. The upper three address bits pick one of eight 4096-word memory modules and the lower twelve bits pick the word inside that module. The word currently held is discarded, and fetching restarts at the chosen syllable.

The memory side is a simple request/acknowledge pair. The block holds `mem_req` with `mem_addr` until the memory raises `mem_ack`, and `mem_rdata` is taken in the acknowledge cycle. The decoder side is a valid/ready pair.

Top module: `syllable_pair_fetcher`

## Requirements
- R1: After reset the block requests word address 0, `insn_valid` is 0 and `par_err` is 0.
- R2: Syllable 0 occupies word bits [13:0]: instruction bits [12:0] with its parity bit at bit 13. Syllable 1 occupies bits [27:14]: instruction bits [26:14] with its parity bit at bit 27. Syllable 0 of a word is presented before syllable 1. `insn_addr` and `insn_syl` identify the syllable on `insn_bits`.
- R3: While a word is held, `mem_req` stays low. A new read is issued only after syllable 1 of the held word has been consumed or dropped, or after a redirect. That read goes to the next word address. A run through k whole words from syllable 0 costs k reads plus one prefetch.
- R4: A syllable is presented as valid only when its 13 instruction bits and its parity bit together contain an odd number of ones.
- R5: A syllable with even parity is not presented. `insn_par_fail` pulses for exactly one cycle and the syllable is skipped without waiting for `insn_ready`. `par_err` goes high on the next cycle and stays high until reset.
- R6: A redirect discards the held word. On the next cycle the block requests `redirect_addr`, and the first syllable it then presents is the one chosen by `redirect_syl` (0 or 1).
- R7: The word address steps across a module boundary: offset 4095 of module m is followed by offset 0 of module m+1, and address 32767 is followed by address 0.
- R8: While `insn_valid` is high and `insn_ready` is low, the presented syllable, its bits and its address stay unchanged.
- R9: A redirect in the same cycle as a memory acknowledge wins. The returned word is ignored, and the first presented syllable comes from the redirect target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Word read request |
| mem_addr | output | 15 | Word address: module in [14:12], offset in [11:0] |
| mem_ack | input | 1 | Memory returns `mem_rdata` this cycle |
| mem_rdata | input | 28 | Fetched word holding two syllables |
| redirect | input | 1 | Branch: load a new fetch point |
| redirect_addr | input | 15 | Target word address |
| redirect_syl | input | 1 | Target syllable within the word |
| insn_ready | input | 1 | Decoder accepts the presented syllable |
| insn_valid | output | 1 | A syllable with correct parity is presented |
| insn_bits | output | 13 | Instruction bits of the presented syllable |
| insn_syl | output | 1 | Index of the presented syllable |
| insn_addr | output | 15 | Word address the presented syllable came from |
| insn_par_fail | output | 1 | The held syllable fails parity and is being dropped |
| par_err | output | 1 | Sticky parity-error flag |

## Verification
The assertions assume that `mem_ack` is raised only while `mem_req` is high, and that `mem_rdata` is meaningful in the acknowledge cycle. The bench memory model acknowledges only a pending request, after a latency that each scenario chooses, and it computes the returned word from the address alone. The bench issues redirects only while the decoder side is idle, so a redirect never coincides with an accepted syllable. It keeps `redirect_syl` at 0 or 1.

// File: rtl/sylf_pkg.sv
package sylf_pkg;

  typedef enum logic {
    FS_REQ  = 1'b0,
    FS_HOLD = 1'b1
  } fetch_state_e;

  // odd parity holds when the vector has an odd number of ones
  function automatic logic odd_ones(input logic [63:0] v);
    return ^v;
  endfunction

  // next word address inside a space of 2**w words, wrapping at the top
  function automatic logic [63:0] word_addr_inc(input logic [63:0] a,
                                                input int unsigned w);
    logic [63:0] mask;
    mask = (64'd1 << w) - 64'd1;
    return (a + 64'd1) & mask;
  endfunction

endpackage

// File: rtl/sylf_syl_check.sv
module sylf_syl_check #(
  parameter int unsigned INSN_W = 13
) (
  input  logic [INSN_W:0]   slice,
  output logic [INSN_W-1:0] bits,
  output logic              par_ok
);
  import sylf_pkg::*;

  assign bits   = slice[INSN_W-1:0];
  assign par_ok = odd_ones(64'(slice));

endmodule

// File: rtl/sylf_word_ctr.sv
module sylf_word_ctr #(
  parameter int unsigned MOD_W = 3,
  parameter int unsigned OFS_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic [MOD_W+OFS_W-1:0] load_addr,
  input  logic                   step,
  output logic [MOD_W+OFS_W-1:0] addr
);
  import sylf_pkg::*;

  localparam int unsigned ADDR_W = MOD_W + OFS_W;

  logic [OFS_W-1:0] ofs;
  logic [MOD_W-1:0] mdl;
  logic             ofs_top;

  assign ofs     = addr[OFS_W-1:0];
  assign mdl     = addr[ADDR_W-1:OFS_W];
  assign ofs_top = (ofs == {OFS_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr <= '0;
    else if (load)
      addr <= load_addr;
    else if (step)
      addr <= ADDR_W'(word_addr_inc(64'(addr), ADDR_W));
  end

  // R7
  ofs_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && ofs_top |=>
      (ofs == '0) && (mdl == MOD_W'($past(mdl) + 1'b1)))
    else $error("offset wrap did not carry into module field");

  // R7
  ofs_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load && !ofs_top |=>
      (ofs == OFS_W'($past(ofs) + 1'b1)) && (mdl == $past(mdl)))
    else $error("offset step disturbed module field");

endmodule

// File: rtl/sylf_seq.sv
module sylf_seq #(
  parameter int unsigned NSYL = 2,
  localparam int unsigned PW  = (NSYL > 1) ? $clog2(NSYL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [PW-1:0] redirect_syl,
  input  logic          mem_ack,
  input  logic          take,
  input  logic          drop,
  output logic          held,
  output logic [PW-1:0] ptr,
  output logic          capture,
  output logic          step,
  output logic          load,
  output logic          mem_req
);
  import sylf_pkg::*;

  localparam logic [PW-1:0] LAST = PW'(NSYL - 1);

  fetch_state_e  state;
  logic [PW-1:0] start_q;
  logic          advance;

  assign held    = (state == FS_HOLD);
  assign mem_req = (state == FS_REQ);
  assign load    = redirect;
  assign capture = mem_req & mem_ack & ~redirect;
  assign advance = held & (take | drop) & ~redirect;
  assign step    = advance & (ptr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= FS_REQ;
      ptr     <= '0;
      start_q <= '0;
    end else if (redirect) begin
      state   <= FS_REQ;
      start_q <= redirect_syl;
    end else if (capture) begin
      state <= FS_HOLD;
      ptr   <= start_q;
    end else if (step) begin
      state   <= FS_REQ;
      start_q <= '0;
    end else if (advance) begin
      ptr <= ptr + 1'b1;
    end
  end

  // input assumption: memory answers only a pending request
  ack_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> mem_req)
    else $error("acknowledge without request");

  // R3
  req_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(step || load))
    else $error("read issued before the held word was used up");

  // R9
  ack_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect && mem_ack |=> !held)
    else $error("word captured despite redirect");

endmodule

// File: rtl/syllable_pair_fetcher.sv
module syllable_pair_fetcher #(
  parameter int unsigned MOD_W  = 3,
  parameter int unsigned OFS_W  = 12,
  parameter int unsigned INSN_W = 13,
  parameter int unsigned NSYL   = 2,
  localparam int unsigned ADDR_W  = MOD_W + OFS_W,
  localparam int unsigned SLICE_W = INSN_W + 1,
  localparam int unsigned WORD_W  = NSYL * SLICE_W,
  localparam int unsigned PW      = (NSYL > 1) ? $clog2(NSYL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic [PW-1:0]     redirect_syl,
  input  logic              insn_ready,
  output logic              insn_valid,
  output logic [INSN_W-1:0] insn_bits,
  output logic [PW-1:0]     insn_syl,
  output logic [ADDR_W-1:0] insn_addr,
  output logic              insn_par_fail,
  output logic              par_err
);

  logic [WORD_W-1:0] word_q;
  logic              held, capture, step, load, take, drop;
  logic [PW-1:0]     ptr;
  logic [ADDR_W-1:0] addr;

  logic [INSN_W-1:0]  slot_bits [NSYL];
  logic [NSYL-1:0]    slot_ok;
  logic [SLICE_W-1:0] slot_raw  [NSYL];
  logic               sel_ok;
  logic [SLICE_W-1:0] sel_raw;

  sylf_seq #(.NSYL(NSYL)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .redirect    (redirect),
    .redirect_syl(redirect_syl),
    .mem_ack     (mem_ack),
    .take        (take),
    .drop        (drop),
    .held        (held),
    .ptr         (ptr),
    .capture     (capture),
    .step        (step),
    .load        (load),
    .mem_req     (mem_req)
  );

  sylf_word_ctr #(.MOD_W(MOD_W), .OFS_W(OFS_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_addr(redirect_addr),
    .step     (step),
    .addr     (addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      word_q <= '0;
    else if (capture)
      word_q <= mem_rdata;
  end

  // one parity checker per syllable slot of the held word
  for (genvar g = 0; g < NSYL; g++) begin : g_slot
    assign slot_raw[g] = word_q[g*SLICE_W +: SLICE_W];
    sylf_syl_check #(.INSN_W(INSN_W)) u_chk (
      .slice (slot_raw[g]),
      .bits  (slot_bits[g]),
      .par_ok(slot_ok[g])
    );
  end

  assign sel_ok  = slot_ok[ptr];
  assign sel_raw = slot_raw[ptr];

  assign mem_addr      = addr;
  assign insn_addr     = addr;
  assign insn_syl      = ptr;
  assign insn_bits     = slot_bits[ptr];
  assign insn_valid    = held & sel_ok;
  assign insn_par_fail = held & ~sel_ok;
  assign take          = insn_valid & insn_ready;
  assign drop          = insn_par_fail;

  always_ff @(posedge clk) begin
    if (!rst_n)
      par_err <= 1'b0;
    else if (insn_par_fail)
      par_err <= 1'b1;
  end

  // R4
  always_comb begin
    if (rst_n && insn_valid)
      odd_valid_chk: assert (^sel_raw)
        else $error("valid syllable with even parity");
  end

  // R5
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_par_fail |=> par_err)
    else $error("parity failure did not raise the flag");

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |=> par_err)
    else $error("error flag cleared without reset");

  // R6
  redirect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> mem_req && (mem_addr == $past(redirect_addr)))
    else $error("redirect target not requested");

  // R9
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !insn_valid)
    else $error("stale syllable presented after redirect");

  // R8
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && !insn_ready && !redirect |=>
      insn_valid && $stable(insn_bits) && $stable(insn_syl) && $stable(insn_addr))
    else $error("presented syllable changed during stall");

endmodule

// File: tb/syllable_pair_fetcher_bench.sv
module syllable_pair_fetcher_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [14:0] addr;
    logic        syl;
    logic [12:0] bits;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_ack;
  logic [14:0] mem_addr;
  logic [27:0] mem_rdata;
  logic        redirect = 1'b0;
  logic [14:0] redirect_addr = '0;
  logic        redirect_syl = 1'b0;
  logic        insn_ready = 1'b0;
  logic        insn_valid, insn_par_fail, par_err;
  logic [12:0] insn_bits;
  logic        insn_syl;
  logic [14:0] insn_addr;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  string       tag = "R2";
  int          lat = 0;
  logic [14:0] bad_addr = 15'h1234;
  logic        bad_syl = 1'b0;
  logic        stall_mode = 1'b0;
  int          wcnt = 0;
  int          hs_cnt = 0;
  int          fail_pulses = 0;
  int          cyc = 0;
  logic        prev_pend = 1'b0;
  logic [12:0] prev_bits = '0;
  logic        done = 1'b0;

  syllable_pair_fetcher u_syllable_pair_fetcher (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .redirect(redirect), .redirect_addr(redirect_addr), .redirect_syl(redirect_syl),
    .insn_ready(insn_ready), .insn_valid(insn_valid), .insn_bits(insn_bits),
    .insn_syl(insn_syl), .insn_addr(insn_addr),
    .insn_par_fail(insn_par_fail), .par_err(par_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // instruction content is a pure function of address and syllable
  function automatic logic [12:0] insn_of(logic [14:0] a, logic s);
    if (s) return 13'((a * 7) ^ 15'h1555);
    return 13'(a * 3 + 15'h00A5);
  endfunction

  // R2 layout: syllable s at bits [14*s+13 : 14*s], parity on top, odd overall
  function automatic logic [27:0] word_of(logic [14:0] a, logic [14:0] ba, logic bs);
    logic [27:0] w;
    w = '0;
    for (int s = 0; s < 2; s++) begin
      logic [12:0] ins;
      logic        p;
      ins = insn_of(a, s[0]);
      p   = ~(^ins);
      if (a == ba && s[0] == bs) p = ~p;
      w[s*14 +: 14] = {p, ins};
    end
    return w;
  endfunction

  assign mem_ack   = mem_req && (wcnt >= lat);
  assign mem_rdata = word_of(mem_addr, bad_addr, bad_syl);

  always @(posedge clk) begin
    if (mem_req && !mem_ack) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  task automatic chk(bit ok, string r, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // monitor / scoreboard: decide ready for the coming edge, pop on acceptance
  always @(negedge clk) begin
    if (rst_n) begin
      logic rn;
      cyc++;
      if (mem_req && mem_ack) hs_cnt++;
      if (insn_par_fail) fail_pulses++;
      if (insn_valid)
        chk(!mem_req, "R3", "read while word held", 64'(mem_req), 64'd0);
      if (insn_valid && prev_pend)
        chk(insn_bits == prev_bits, "R8", "stalled syllable changed",
            64'(insn_bits), 64'(prev_bits));
      rn = (q.size() > 0) && (!stall_mode || (cyc % 3 == 0));
      if (insn_valid && rn) begin
        exp_t e;
        e = q.pop_front();
        chk({insn_addr, insn_syl, insn_bits} == e, tag, "presented syllable",
            64'({insn_addr, insn_syl, insn_bits}), 64'(e));
      end
      prev_pend  = insn_valid && !rn;
      prev_bits  = insn_bits;
      insn_ready = rn;
    end
  end

  task automatic push_from(logic [14:0] a, logic s, int n);
    logic [14:0] ca;
    logic        cs;
    ca = a;
    cs = s;
    for (int i = 0; i < n; i++) begin
      if (!(ca == bad_addr && cs == bad_syl))
        q.push_back({ca, cs, insn_of(ca, cs)});
      if (cs) ca = ca + 15'd1;
      cs = ~cs;
    end
  endtask

  task automatic drain();
    while (q.size() != 0) @(posedge clk);
    repeat (6) @(posedge clk);
    #1;
  endtask

  task automatic redirect_to(logic [14:0] a, logic s, int n, output int hs_mark);
    @(posedge clk); #1;
    redirect = 1'b1; redirect_addr = a; redirect_syl = s;
    @(posedge clk); #1;
    redirect = 1'b0;
    hs_mark = hs_cnt;
    push_from(a, s, n);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    int hm;
    int fm;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(mem_req == 1'b1, "R1", "mem_req after reset", 64'(mem_req), 64'd1);
    chk(mem_addr == 15'd0, "R1", "mem_addr after reset", 64'(mem_addr), 64'd0);
    chk(insn_valid == 1'b0, "R1", "insn_valid after reset", 64'(insn_valid), 64'd0);
    chk(par_err == 1'b0, "R1", "par_err after reset", 64'(par_err), 64'd0);

    // R2 order and layout from word 0
    tag = "R2";
    push_from(15'd0, 1'b0, 6);
    drain();

    // R3 one read per word plus one prefetch, with memory latency
    tag = "R3"; lat = 2;
    redirect_to(15'h100, 1'b0, 8, hm);
    drain();
    chk(hs_cnt - hm == 5, "R3", "reads for four words", 64'(hs_cnt - hm), 64'd5);
    chk(mem_req == 1'b0, "R3", "idle while next word held", 64'(mem_req), 64'd0);

    // R6 redirect into syllable 1
    tag = "R6"; lat = 1;
    redirect_to(15'h2A5, 1'b1, 5, hm);
    drain();

    // R8 decoder stalls
    tag = "R8"; stall_mode = 1'b1;
    redirect_to(15'h333, 1'b0, 7, hm);
    drain();
    stall_mode = 1'b0;

    // R7 module boundary and top-of-space wrap
    tag = "R7";
    redirect_to(15'h0FFF, 1'b1, 3, hm);
    drain();
    redirect_to(15'h7FFF, 1'b0, 3, hm);
    drain();

    // R9 redirect coinciding with acknowledge
    tag = "R9"; lat = 0;
    @(posedge clk); #1;
    redirect = 1'b1; redirect_addr = 15'h500; redirect_syl = 1'b0;
    @(posedge clk); #1;
    redirect_addr = 15'h600; redirect_syl = 1'b1;
    chk(mem_req && mem_ack, "R9", "ack pending with redirect", 64'(mem_req && mem_ack), 64'd1);
    @(posedge clk); #1;
    redirect = 1'b0;
    push_from(15'h600, 1'b1, 3);
    drain();

    // R5 parity failure in syllable 0, flag sticky
    tag = "R5";
    chk(par_err == 1'b0, "R5", "flag clear before any failure", 64'(par_err), 64'd0);
    fm = fail_pulses;
    bad_addr = 15'h040; bad_syl = 1'b0;
    redirect_to(15'h03F, 1'b0, 6, hm);
    drain();
    chk(fail_pulses - fm == 1, "R5", "failure pulses", 64'(fail_pulses - fm), 64'd1);
    chk(par_err == 1'b1, "R5", "flag after failure", 64'(par_err), 64'd1);

    // R4 redirect straight onto a bad syllable 1: skipped to next word
    tag = "R4";
    bad_addr = 15'h050; bad_syl = 1'b1;
    redirect_to(15'h050, 1'b1, 3, hm);
    drain();
    chk(fail_pulses - fm == 2, "R4", "second failure pulse", 64'(fail_pulses - fm), 64'd2);
    chk(par_err == 1'b1, "R5", "flag still set", 64'(par_err), 64'd1);
    chk(q.size() == 0, "R4", "all expected syllables seen", 64'(q.size()), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule